// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Interlock

This block is a multi-cycle integer multiply and divide engine that works beside a single-cycle ALU. It takes one operation at a time. Each operation is 32-bit or 64-bit, signed or unsigned, and is either a multiply or a divide. The result goes into two architectural registers. LO gets the low half of a product or the quotient. HI gets the high half of a product or the remainder. Each operation class has a fixed latency, and the repeat interval equals that latency.

The pipeline keeps issuing other work while the unit is busy. A stall is requested only when the pipeline reads HI or LO before the running operation has written them, or presents a new operation before the unit can take it. A held operation waits with `op_valid` high. It is accepted on the completion cycle of the running one, so back-to-back issue proceeds at the repeat rate. Multiplies form the full product when they are accepted and wait out the latency. Divides run one restoring step per cycle, and the step count fits inside the latency.

Top module: `imd_unit`

## Requirements
- R1: While reset is asserted and after it is released, HI and LO read zero, and busy and stall are low.
- R2: `op_code` is decoded as bit 2 = divide, bit 1 = 64-bit width, bit 0 = unsigned. An operation is accepted on a clock edge where `op_valid` is high and the unit is idle or completing. Busy then stays high for exactly 8 cycles (32-bit multiply), 12 (64-bit multiply), 36 (32-bit divide) or 68 (64-bit divide). HI/LO are written on the edge where busy falls.
- R3: A multiply writes the low half of the full, correctly signed or unsigned product to LO and the high half to HI.
- R4: A divide writes to LO the quotient truncated toward zero and to HI the remainder, which carries the dividend's sign.
- R5: A 32-bit operation uses only bits 31:0 of each operand. Its HI and LO results are each sign-extended from bit 31 to the full width.
- R6: Asserting `rd_hi` or `rd_lo` while busy raises `stall`. When the unit is idle, `stall` stays low.
- R7: An operation presented while the unit is busy and not completing raises `stall`, is not accepted and does not disturb the running operation. It is taken on the completion edge, so the issue interval equals the latency.
- R8: HI and LO change only on the edge that completes an operation.
- R9: Divide by zero takes the normal latency and leaves an all-ones quotient and a remainder equal to the dividend, at the operation's width.
- R10: Signed division of the most negative value by -1 gives the most negative value as quotient and zero as remainder.
- R11: `rd_data` returns HI when `rd_hi` is high and LO otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request, held until accepted |
| op_code | input | 3 | {divide, 64-bit, unsigned} |
| op_a | input | XLEN | Multiplicand or dividend |
| op_b | input | XLEN | Multiplier or divisor |
| rd_hi | input | 1 | Read request for HI |
| rd_lo | input | 1 | Read request for LO |
| rd_data | output | XLEN | Selected HI or LO value |
| hi_q | output | XLEN | HI register |
| lo_q | output | XLEN | LO register |
| busy | output | 1 | Operation in flight |
| stall | output | 1 | Pipeline hold request |

## Verification
On every cycle, the assertions check the following:
- the busy window matches the latency latched at acceptance;
- a busy unit takes no new operation;
- reads during busy stall, and an idle unit never stalls;
- HI/LO move only on completion, and narrow results arrive sign-extended;
- the divider has finished its steps when the result is written, and its partial remainder stays below the divisor.

Only the bench's scenarios can show that the values are right, because they compare results against an independent wide-arithmetic model. Those scenarios are an operand sweep across all eight operation codes, the divide-by-zero and overflow corners, the use of operand upper bits in narrow operations, and held issue at the repeat rate.

// File: rtl/imd_pkg.sv
package imd_pkg;
  // op_code bit order: {is_div, wide, uns}
  typedef struct packed {
    logic is_div;
    logic wide;
    logic uns;
  } imd_op_t;
endpackage

// File: rtl/imd_ctrl.sv
module imd_ctrl #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] lat_m1,
  output logic          busy,
  output logic          fin
);
  logic [CW-1:0] cnt;
  // observation state for the latency check
  logic [CW-1:0] age;
  logic [CW-1:0] lat_q;

  assign fin = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= lat_m1;
    end else if (fin) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age   <= '0;
      lat_q <= '0;
    end else if (start) begin
      age   <= CW'(1);
      lat_q <= lat_m1 + 1'b1;
    end else if (busy) begin
      age <= age + 1'b1;
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (age == lat_q));

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !start) |=> !busy);
endmodule

// File: rtl/imd_mul_core.sv
module imd_mul_core #(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  input  logic              sgn,
  input  logic              wide,
  output logic [2*XLEN-1:0] prod
);
  localparam int HALF = XLEN / 2;
  localparam int PW   = 2 * XLEN;

  function automatic logic [PW-1:0] ext_op(input logic [XLEN-1:0] x,
                                           input logic sg, input logic wd);
    if (wd) return sg ? {{XLEN{x[XLEN-1]}}, x} : {{XLEN{1'b0}}, x};
    return sg ? {{(PW-HALF){x[HALF-1]}}, x[HALF-1:0]}
              : {{(PW-HALF){1'b0}}, x[HALF-1:0]};
  endfunction

  function automatic logic [PW-1:0] full_mul(input logic [XLEN-1:0] x,
                                             input logic [XLEN-1:0] y,
                                             input logic sg, input logic wd);
    logic [PW-1:0] ex, ey;
    ex = ext_op(x, sg, wd);
    ey = ext_op(y, sg, wd);
    return ex * ey;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) prod <= '0;
    else if (start) prod <= full_mul(a, b, sgn, wide);
  end
endmodule

// File: rtl/imd_div_core.sv
module imd_div_core #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sgn,
  input  logic            wide,
  output logic [XLEN-1:0] quo_s,
  output logic [XLEN-1:0] rem_s,
  output logic            idle
);
  localparam int HALF = XLEN / 2;
  localparam int SW   = $clog2(XLEN + 1);

  logic [XLEN-1:0] quo, rem, dvs;
  logic [SW-1:0]   left;
  logic            neg_q, neg_r;
  logic [XLEN-1:0] va, vb, ma, mb;
  logic [XLEN:0]   shifted, trial;

  function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] x,
                                            input logic sg, input logic wd);
    if (wd) return x;
    return sg ? {{HALF{x[HALF-1]}}, x[HALF-1:0]} : {{HALF{1'b0}}, x[HALF-1:0]};
  endfunction

  always_comb begin
    va = widen(a, sgn, wide);
    vb = widen(b, sgn, wide);
    ma = (sgn && va[XLEN-1]) ? -va : va;
    mb = (sgn && vb[XLEN-1]) ? -vb : vb;
    shifted = {rem, quo[XLEN-1]};
    trial   = shifted - {1'b0, dvs};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo   <= '0;
      rem   <= '0;
      dvs   <= '0;
      left  <= '0;
      neg_q <= 1'b0;
      neg_r <= 1'b0;
    end else if (start) begin
      quo   <= wide ? ma : (ma << HALF);
      rem   <= '0;
      dvs   <= mb;
      left  <= wide ? SW'(XLEN) : SW'(HALF);
      neg_q <= sgn && (va[XLEN-1] ^ vb[XLEN-1]) && (vb != '0);
      neg_r <= sgn && va[XLEN-1];
    end else if (left != '0) begin
      if (!trial[XLEN]) begin
        rem <= trial[XLEN-1:0];
        quo <= {quo[XLEN-2:0], 1'b1};
      end else begin
        rem <= shifted[XLEN-1:0];
        quo <= {quo[XLEN-2:0], 1'b0};
      end
      left <= left - 1'b1;
    end
  end

  assign idle  = (left == '0);
  assign quo_s = neg_q ? -quo : quo;
  assign rem_s = neg_r ? -rem : rem;

  p_rem_below_divisor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dvs != '0) |-> (rem < dvs));
endmodule

// File: rtl/imd_unit.sv
module imd_unit
  import imd_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int LAT_MUL_N = 8,
  parameter int LAT_MUL_W = 12,
  parameter int LAT_DIV_N = 36,
  parameter int LAT_DIV_W = 68
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            rd_hi,
  input  logic            rd_lo,
  output logic [XLEN-1:0] rd_data,
  output logic [XLEN-1:0] hi_q,
  output logic [XLEN-1:0] lo_q,
  output logic            busy,
  output logic            stall
);
  localparam int HALF  = XLEN / 2;
  localparam int LM_A  = (LAT_MUL_N > LAT_MUL_W) ? LAT_MUL_N : LAT_MUL_W;
  localparam int LM_B  = (LAT_DIV_N > LAT_DIV_W) ? LAT_DIV_N : LAT_DIV_W;
  localparam int LAT_MAX = (LM_A > LM_B) ? LM_A : LM_B;
  localparam int CW    = $clog2(LAT_MAX + 1);

  imd_op_t          op_in, op_q;
  logic             start, fin, div_idle;
  logic [CW-1:0]    lat_m1;
  logic [2*XLEN-1:0] prod;
  logic [XLEN-1:0]  quo_s, rem_s;

  function automatic logic [XLEN-1:0] sext_half(input logic [HALF-1:0] x);
    return {{HALF{x[HALF-1]}}, x};
  endfunction

  assign op_in = imd_op_t'(op_code);
  assign start = op_valid && (!busy || fin);

  always_comb begin
    case ({op_in.is_div, op_in.wide})
      2'b00:   lat_m1 = CW'(LAT_MUL_N - 1);
      2'b01:   lat_m1 = CW'(LAT_MUL_W - 1);
      2'b10:   lat_m1 = CW'(LAT_DIV_N - 1);
      default: lat_m1 = CW'(LAT_DIV_W - 1);
    endcase
  end

  imd_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .lat_m1(lat_m1),
    .busy(busy), .fin(fin)
  );

  imd_mul_core #(.XLEN(XLEN)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(start && !op_in.is_div),
    .a(op_a), .b(op_b), .sgn(!op_in.uns), .wide(op_in.wide), .prod(prod)
  );

  imd_div_core #(.XLEN(XLEN)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start && op_in.is_div),
    .a(op_a), .b(op_b), .sgn(!op_in.uns), .wide(op_in.wide),
    .quo_s(quo_s), .rem_s(rem_s), .idle(div_idle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) op_q <= '0;
    else if (start) op_q <= op_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (fin) begin
      case ({op_q.is_div, op_q.wide})
        2'b00: begin
          lo_q <= sext_half(prod[HALF-1:0]);
          hi_q <= sext_half(prod[XLEN-1:HALF]);
        end
        2'b01: begin
          lo_q <= prod[XLEN-1:0];
          hi_q <= prod[2*XLEN-1:XLEN];
        end
        2'b10: begin
          lo_q <= sext_half(quo_s[HALF-1:0]);
          hi_q <= sext_half(rem_s[HALF-1:0]);
        end
        default: begin
          lo_q <= quo_s;
          hi_q <= rem_s;
        end
      endcase
    end
  end

  assign rd_data = rd_hi ? hi_q : lo_q;
  assign stall   = busy && (rd_hi || rd_lo || (op_valid && !fin));

  p_read_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (rd_hi || rd_lo)) |-> stall);

  p_idle_nostall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stall);

  p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> (busy && $stable(op_q)));

  p_write_on_fin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_q != $past(hi_q)) || (lo_q != $past(lo_q))) |-> $past(fin));

  p_narrow_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !op_q.wide) |=>
      ((hi_q[XLEN-1:HALF] == {HALF{hi_q[HALF-1]}}) &&
       (lo_q[XLEN-1:HALF] == {HALF{lo_q[HALF-1]}})));

  p_div_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_q.is_div) |-> div_idle);
endmodule

// File: tb/imd_unit_tb.sv
module imd_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        rd_hi = 1'b0, rd_lo = 1'b0;
  logic [63:0] rd_data, hi_q, lo_q;
  logic        busy, stall;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .rd_data(rd_data), .hi_q(hi_q), .lo_q(lo_q), .busy(busy), .stall(stall)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int lat_of(input logic [2:0] op);
    case (op[2:1])
      2'b00:   return 8;
      2'b01:   return 12;
      2'b10:   return 36;
      default: return 68;
    endcase
  endfunction

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // returns {hi, lo}
  function automatic logic [127:0] model(input logic [2:0] op,
                                         input logic [63:0] a, input logic [63:0] b);
    logic signed [127:0] x, y, p, q, r;
    logic [63:0] hi, lo;
    if (op[1]) begin
      x = op[0] ? {64'b0, a} : {{64{a[63]}}, a};
      y = op[0] ? {64'b0, b} : {{64{b[63]}}, b};
    end else begin
      x = op[0] ? {96'b0, a[31:0]} : {{96{a[31]}}, a[31:0]};
      y = op[0] ? {96'b0, b[31:0]} : {{96{b[31]}}, b[31:0]};
    end
    if (!op[2]) begin
      p = x * y;
      lo = op[1] ? p[63:0]   : sx32(p[31:0]);
      hi = op[1] ? p[127:64] : sx32(p[63:32]);
    end else begin
      if (y == 0) begin
        q = {128{1'b1}};
        r = x;
      end else begin
        q = x / y;
        r = x % y;
      end
      lo = op[1] ? q[63:0] : sx32(q[31:0]);
      hi = op[1] ? r[63:0] : sx32(r[31:0]);
    end
    return {hi, lo};
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [63:0] a,
                        input logic [63:0] b, input bit full);
    logic [127:0] exp;
    logic [63:0] prev_hi;
    int n;
    string rtag;
    exp = model(op, a, b);
    rtag = op[2] ? "R4" : "R3";
    prev_hi = hi_q;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
    n = 0;
    while (busy && n < 200) begin
      n++;
      if (full && n == 1) begin
        rd_lo = 1'b1;
        #1;
        chk(stall === 1'b1, "R6 read while busy stalls", {127'b0, stall}, 128'd1);
        chk(hi_q === prev_hi, "R8 HI held while busy", {64'b0, hi_q}, {64'b0, prev_hi});
        rd_lo = 1'b0;
      end
      @(negedge clk);
    end
    if (full) chk(n == lat_of(op), "R2 latency", 128'(n), 128'(lat_of(op)));
    chk({hi_q, lo_q} === exp, rtag, {hi_q, lo_q}, exp);
    if (full) begin
      rd_hi = 1'b1;
      #1;
      chk(rd_data === hi_q && stall === 1'b0, "R11 HI read idle",
          {63'b0, stall, rd_data}, {64'b0, hi_q});
      rd_hi = 1'b0;
      #1;
      chk(rd_data === lo_q, "R11 LO read", {64'b0, rd_data}, {64'b0, lo_q});
    end
  endtask

  task automatic run_tag(input string tag, input logic [2:0] op,
                         input logic [63:0] a, input logic [63:0] b);
    logic [127:0] exp;
    exp = model(op, a, b);
    run_op(op, a, b, 1'b0);
    chk({hi_q, lo_q} === exp, tag, {hi_q, lo_q}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] e1, e2;
    int n;
    repeat (3) @(negedge clk);
    rd_hi = 1'b1;
    #1;
    chk(busy === 1'b0 && stall === 1'b0, "R1 reset flags", {126'b0, busy, stall}, 128'd0);
    chk(hi_q === 64'd0 && lo_q === 64'd0, "R1 reset HI/LO", {hi_q, lo_q}, 128'd0);
    rd_hi = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && hi_q === 64'd0, "R1 after release", {63'b0, busy, hi_q}, 128'd0);

    // sweep: all op codes over small signed operands
    for (int op = 0; op < 8; op++)
      for (int ia = -3; ia <= 3; ia++)
        for (int ib = -3; ib <= 3; ib++)
          run_op(3'(op), 64'(ia), 64'(ib), (ia == 2 && ib == -3));

    // narrow ops ignore operand upper bits, results sign-extended (R5)
    run_tag("R5 narrow mul upper bits", 3'b000, {32'hDEADBEEF, 32'h8000_0001}, {32'h1234_5678, 32'h7FFF_FFFF});
    run_tag("R5 narrow divu upper bits", 3'b101, {32'hFFFF_0000, 32'hF000_0000}, {32'h0000_0001, 32'h0000_0003});
    run_tag("R5 narrow div neg", 3'b100, {32'h5555_5555, 32'hFFFF_FF9C}, {32'hAAAA_AAAA, 32'h0000_0007});

    // full-width multiply extremes (R3)
    run_tag("R3 wide mulu max", 3'b011, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    run_tag("R3 wide mul min", 3'b010, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    run_tag("R3 wide mul mix", 3'b010, 64'h8000_0000_0000_0000, 64'd3);
    run_tag("R4 wide divu big", 3'b111, 64'hFFFF_FFFF_FFFF_FFFF, 64'd10);
    run_tag("R4 wide div neg", 3'b110, 64'hFFFF_FFFF_FFFF_FF85, 64'd10);

    // divide by zero (R9)
    run_tag("R9 div0 wide signed", 3'b110, 64'hFFFF_FFFF_FFFF_FFF9, 64'd0);
    run_tag("R9 div0 narrow unsigned", 3'b101, 64'h0000_0000_8000_0005, 64'hFFFF_FFFF_0000_0000);
    chk(lo_q === 64'hFFFF_FFFF_FFFF_FFFF && hi_q === 64'hFFFF_FFFF_8000_0005,
        "R9 div0 explicit", {hi_q, lo_q}, {64'hFFFF_FFFF_8000_0005, 64'hFFFF_FFFF_FFFF_FFFF});
    run_op(3'b100, 64'd77, 64'd0, 1'b1);

    // overflow (R10)
    run_op(3'b110, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    chk(lo_q === 64'h8000_0000_0000_0000 && hi_q === 64'd0, "R10 wide min/-1",
        {hi_q, lo_q}, {64'd0, 64'h8000_0000_0000_0000});
    run_op(3'b100, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0);
    chk(lo_q === 64'hFFFF_FFFF_8000_0000 && hi_q === 64'd0, "R10 narrow min/-1",
        {hi_q, lo_q}, {64'd0, 64'hFFFF_FFFF_8000_0000});

    // held issue at repeat rate (R7)
    e1 = model(3'b000, 64'd5, 64'd7);
    e2 = model(3'b010, 64'd123456789, 64'hFFFF_FFFF_FFFF_FF00);
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'b000; op_a = 64'd5; op_b = 64'd7;
    @(negedge clk);
    op_code = 3'b010; op_a = 64'd123456789; op_b = 64'hFFFF_FFFF_FFFF_FF00;
    n = 0;
    for (int k = 0; k < 8; k++) begin
      #1;
      if (stall) n++;
      @(negedge clk);
    end
    chk(n == 7, "R7 stall cycles while held", 128'(n), 128'd7);
    chk(busy === 1'b1 && {hi_q, lo_q} === e1, "R7 first result, second accepted",
        {127'b0, busy} ^ {hi_q, lo_q}, {127'b0, 1'b1} ^ e1);
    op_valid = 1'b0;
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
    chk(n == 12, "R7 second op latency", 128'(n), 128'd12);
    chk({hi_q, lo_q} === e2, "R7 second op result", {hi_q, lo_q}, e2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule